// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the AXI4-Lite register slave for a single DMA channel. It holds a control word and a status word. Software writes the control word to start and stop the channel, to request a graceful reset of the channel and to enable the three interrupt sources. It reads the status word to see whether the channel is halted or idle, which bus errors have been seen and which interrupt events are pending. The datapath and the interrupt coalescing logic are separate blocks. They connect through level and pulse ports: a run request, a reset request, the shutdown and reset-complete handshakes, transfer start and done pulses, error pulses and interrupt event pulses.

A channel state machine follows these handshakes. Its states are HALTED, RUNNING, STOPPING and RESETTING, and its transitions are these:

- HALTED goes to RUNNING when run/stop is 1.
- HALTED goes to RESETTING when the reset bit is 1.
- RUNNING goes to STOPPING when run/stop drops.
- RUNNING goes to RESETTING when the reset bit is 1.
- STOPPING goes to HALTED when `dp_stopped` is high.
- STOPPING goes to RESETTING when the reset bit is 1.
- RESETTING goes to HALTED when `dp_reset_done` is high. That same edge restores every register to its reset value.

A reset request takes priority over every other transition. The AXI side uses two small state machines. The write path has WR_IDLE and WR_RESP. It moves to WR_RESP when the address and data are accepted, and it returns to WR_IDLE when `bready` is high. The read path has RD_IDLE and RD_DATA. It moves to RD_DATA on an accepted read address, and it returns to RD_IDLE when `rready` is high.

Register offsets are 0x00 for control and 0x04 for status.

Top module: `dma_chan_regs`

## Requirements
- R1: After `rst_n` is released, control reads 0x00000002 and status reads 0x00000001. `run_req`, `soft_rst_req` and `irq` are all 0.
- R2: Control layout: bit 0 is run/stop, bit 2 is reset, bit 12 enables the completion interrupt, bit 13 enables the delay interrupt and bit 14 enables the error interrupt. Bit 1 always reads 1, and all other bits read 0 whatever value is written. `run_req` follows bit 0.
- R3: A write is taken only in a cycle where `awvalid` and `wvalid` are both high. `awready` and `wready` are high only in such a cycle. A lone `awvalid` gets no ready, no response and no register change. Every write response is OKAY (`bresp` = 0) and is held until `bready`.
- R4: `wstrb` is ignored. All 32 bits of `wdata` are written even when `wstrb` is 0.
- R5: Status bit 0 (halted) falls after run/stop is set. Once run/stop is cleared, halted stays 0 until `dp_stopped` is high, and it rises only then.
- R6: Status bit 1 (idle) is 0 while halted and before the first transfer. A `dp_xfer_done` pulse while the channel is running sets it, and `dp_xfer_start` clears it.
- R7: A `dp_slv_err` pulse sets status bit 5 and a `dp_dec_err` pulse sets status bit 6. Either one also sets the error flag (bit 14) and clears run/stop, and this wins over a write in the same cycle. Bits 5 and 6 are sticky, and writes to them have no effect.
- R8: `ev_ioc` sets status bit 12, `ev_dly` sets bit 13, and errors set bit 14. Writing 1 to any of these bits clears it, and writing 0 leaves it as it is. If an event and a clear arrive in the same cycle, the event wins.
- R9: `irq` is high exactly when a status flag in bits 12 to 14 is set and the control enable at the same bit position is set.
- R10: Writing 1 to control bit 2 raises `soft_rst_req`, and the bit reads 1. While the reset is in progress, control writes are ignored and status bit 0 reads 0. When `dp_reset_done` is high, all registers return to their R1 values and `soft_rst_req` falls.
- R11: A read of any offset other than 0x00 or 0x04 returns 0 with `rresp` OKAY. A write to such an offset changes nothing. Read data is held until `rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write strobes (ignored) |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| run_req | output | 1 | Run request to the datapath |
| soft_rst_req | output | 1 | Graceful reset request to the datapath |
| dp_stopped | input | 1 | Datapath reports full shutdown |
| dp_reset_done | input | 1 | Datapath reports the reset has finished |
| dp_xfer_start | input | 1 | Pulse: a transfer begins |
| dp_xfer_done | input | 1 | Pulse: a transfer completed |
| dp_slv_err | input | 1 | Pulse: slave error on the memory side |
| dp_dec_err | input | 1 | Pulse: decode error on the memory side |
| ev_ioc | input | 1 | Pulse: completion interrupt event |
| ev_dly | input | 1 | Pulse: delay interrupt event |
| irq | output | 1 | Interrupt output |

## Verification
The control word is written with all bits set and a zero strobe, which separates real storage from the constant and reserved bits and shows that strobes are ignored. A stop is issued with `dp_stopped` held low for several cycles before it is raised, which shows whether halted waits for the datapath or just follows run/stop. Interrupt flags are cleared once with a write of 0 and once with a write of 1, each with the enable on and then off. This separates the write-1-clear rule from plain storage and checks the enable masking of `irq`. An error pulse in the running state, a lone write address, an unmapped offset and a control write during a reset check the cases where hardware or the reset state overrides software.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

    localparam int DW     = 32;
    localparam int STRB_W = DW / 8;

    // control word bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_ONE  = 1;
    localparam int CB_SRST = 2;
    localparam int CB_EN0  = 12;   // enables at 12 (ioc), 13 (dly), 14 (err)

    // status word bit positions
    localparam int SB_HALT = 0;
    localparam int SB_IDLE = 1;
    localparam int SB_SLV  = 5;
    localparam int SB_DEC  = 6;
    localparam int SB_FLG0 = 12;   // flags at 12 (ioc), 13 (dly), 14 (err)

    localparam int NUM_IRQ = 3;
    localparam int IRQ_IOC = 0;
    localparam int IRQ_DLY = 1;
    localparam int IRQ_ERR = 2;

    typedef enum logic [1:0] {
        S_HALTED,
        S_RUNNING,
        S_STOPPING,
        S_RESETTING
    } chan_state_e;

    typedef enum logic { WR_IDLE, WR_RESP } wr_state_e;
    typedef enum logic { RD_IDLE, RD_DATA } rd_state_e;

    typedef struct packed {
        logic               run;
        logic               srst;
        logic [NUM_IRQ-1:0] irq_en;
    } ctrl_t;

    typedef struct packed {
        logic               idle;
        logic               slv_err;
        logic               dec_err;
        logic [NUM_IRQ-1:0] flag;
    } stat_t;

    localparam ctrl_t CTRL_RESET = '0;
    localparam stat_t STAT_RESET = '0;

endpackage

// File: rtl/dcr_axil_port.sv
module dcr_axil_port
    import dma_chan_regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DW-1:0]     wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DW-1:0]     rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic [DW-1:0]     rd_word,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [ADDR_W-1:0] rd_addr
);

    wr_state_e wr_q, wr_d;
    rd_state_e rd_q, rd_d;
    logic      wr_take, rd_take;

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= WR_IDLE;
            rd_q <= RD_IDLE;
        end else begin
            wr_q <= wr_d;
            rd_q <= rd_d;
        end
    end

    // next state and outputs
    always_comb begin
        wr_d    = wr_q;
        rd_d    = rd_q;
        wr_take = 1'b0;
        rd_take = 1'b0;
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (wr_q)
            WR_IDLE: begin
                wr_take = awvalid && wvalid;
                awready = wr_take;
                wready  = wr_take;
                if (wr_take) wr_d = WR_RESP;
            end
            WR_RESP: begin
                bvalid = 1'b1;
                if (bready) wr_d = WR_IDLE;
            end
        endcase
        unique case (rd_q)
            RD_IDLE: begin
                arready = 1'b1;
                rd_take = arvalid;
                if (arvalid) rd_d = RD_DATA;
            end
            RD_DATA: begin
                rvalid = 1'b1;
                if (rready) rd_d = RD_IDLE;
            end
        endcase
    end

    // read data capture
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (rd_take) rdata <= rd_word;
    end

    assign bresp   = 2'b00;
    assign rresp   = 2'b00;
    assign wr_en   = wr_take;
    assign wr_addr = awaddr;
    assign wr_data = wdata;
    assign rd_addr = araddr;

endmodule

// File: rtl/dcr_chan_fsm.sv
module dcr_chan_fsm
    import dma_chan_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        srst,
    input  logic        dp_stopped,
    input  logic        dp_reset_done,
    output chan_state_e state,
    output logic        halted,
    output logic        clr_all
);

    chan_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HALTED;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        clr_all = 1'b0;
        unique case (state)
            S_HALTED: begin
                if (srst)     state_d = S_RESETTING;
                else if (run) state_d = S_RUNNING;
            end
            S_RUNNING: begin
                if (srst)      state_d = S_RESETTING;
                else if (!run) state_d = S_STOPPING;
            end
            S_STOPPING: begin
                if (srst)            state_d = S_RESETTING;
                else if (dp_stopped) state_d = S_HALTED;
            end
            S_RESETTING: begin
                if (dp_reset_done) begin
                    state_d = S_HALTED;
                    clr_all = 1'b1;
                end
            end
        endcase
    end

    assign halted = (state == S_HALTED);

endmodule

// File: rtl/dcr_reg_file.sv
module dcr_reg_file
    import dma_chan_regs_pkg::*;
#(
    parameter int              ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  chan_state_e       state,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              ev_ioc,
    input  logic              ev_dly,
    input  logic              dp_slv_err,
    input  logic              dp_dec_err,
    input  logic              dp_xfer_start,
    input  logic              dp_xfer_done,
    output ctrl_t             ctrl,
    output logic [DW-1:0]     rd_word,
    output logic              irq
);

    stat_t              stat;
    logic               ctrl_wr, stat_wr, err_any, live;
    logic [NUM_IRQ-1:0] ev_vec, w1c;
    logic [DW-1:0]      ctrl_word, stat_word;
    logic               unused_wdata;

    assign live    = !ctrl.srst;
    assign ctrl_wr = wr_en && (wr_addr == CTRL_OFS) && live;
    assign stat_wr = wr_en && (wr_addr == STAT_OFS);
    assign err_any = live && (dp_slv_err || dp_dec_err);
    assign w1c     = stat_wr ? wr_data[SB_FLG0 +: NUM_IRQ] : '0;

    always_comb begin
        ev_vec          = '0;
        ev_vec[IRQ_IOC] = live && ev_ioc;
        ev_vec[IRQ_DLY] = live && ev_dly;
        ev_vec[IRQ_ERR] = err_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            ctrl <= CTRL_RESET;
            stat <= STAT_RESET;
        end else begin
            if (ctrl_wr) begin
                ctrl.run    <= wr_data[CB_RUN];
                ctrl.srst   <= wr_data[CB_SRST];
                ctrl.irq_en <= wr_data[CB_EN0 +: NUM_IRQ];
            end
            if (err_any) ctrl.run <= 1'b0;   // hardware stop wins
            stat.flag <= (stat.flag & ~w1c) | ev_vec;
            if (live && dp_slv_err) stat.slv_err <= 1'b1;
            if (live && dp_dec_err) stat.dec_err <= 1'b1;
            if (state == S_HALTED || state == S_RESETTING)
                stat.idle <= 1'b0;
            else if (dp_xfer_start)
                stat.idle <= 1'b0;
            else if (dp_xfer_done)
                stat.idle <= 1'b1;
        end
    end

    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[CB_RUN]                = ctrl.run;
        ctrl_word[CB_ONE]                = 1'b1;
        ctrl_word[CB_SRST]               = ctrl.srst;
        ctrl_word[CB_EN0 +: NUM_IRQ]     = ctrl.irq_en;
        stat_word                        = '0;
        stat_word[SB_HALT]               = (state == S_HALTED);
        stat_word[SB_IDLE]               = stat.idle;
        stat_word[SB_SLV]                = stat.slv_err;
        stat_word[SB_DEC]                = stat.dec_err;
        stat_word[SB_FLG0 +: NUM_IRQ]    = stat.flag;
        if (rd_addr == CTRL_OFS)      rd_word = ctrl_word;
        else if (rd_addr == STAT_OFS) rd_word = stat_word;
        else                          rd_word = '0;
    end

    assign irq          = |(stat.flag & ctrl.irq_en);
    assign unused_wdata = ^wr_data;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic              run_req,
    output logic              soft_rst_req,
    input  logic              dp_stopped,
    input  logic              dp_reset_done,
    input  logic              dp_xfer_start,
    input  logic              dp_xfer_done,
    input  logic              dp_slv_err,
    input  logic              dp_dec_err,
    input  logic              ev_ioc,
    input  logic              ev_dly,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(4);

    ctrl_t              ctrl_q;
    chan_state_e        chan_state;
    logic               chan_halted, clr_all, wr_en;
    logic [ADDR_W-1:0]  wr_addr, rd_addr;
    logic [DW-1:0]      wr_data, rd_word;
    logic [NUM_IRQ-1:0] irq_en_w;
    logic               unused_strb;

    dcr_axil_port #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .rd_word(rd_word), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr)
    );

    dcr_chan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl_q.run), .srst(ctrl_q.srst),
        .dp_stopped(dp_stopped), .dp_reset_done(dp_reset_done),
        .state(chan_state), .halted(chan_halted), .clr_all(clr_all)
    );

    dcr_reg_file #(
        .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .state(chan_state),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .ev_ioc(ev_ioc), .ev_dly(ev_dly),
        .dp_slv_err(dp_slv_err), .dp_dec_err(dp_dec_err),
        .dp_xfer_start(dp_xfer_start), .dp_xfer_done(dp_xfer_done),
        .ctrl(ctrl_q), .rd_word(rd_word), .irq(irq)
    );

    assign run_req      = ctrl_q.run;
    assign soft_rst_req = ctrl_q.srst;
    assign irq_en_w     = ctrl_q.irq_en;
    assign unused_strb  = ^wstrb;   // strobes do not qualify writes

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        awvalid,
    input logic        wvalid,
    input logic        awready,
    input logic        bvalid,
    input logic        bready,
    input logic        rvalid,
    input logic        rready,
    input logic [31:0] rdata,
    input logic        halted,
    input logic        run_req,
    input logic        soft_rst_req,
    input logic        dp_stopped,
    input logic        dp_reset_done,
    input logic        dp_slv_err,
    input logic        dp_dec_err,
    input logic        irq,
    input logic [2:0]  irq_en
);

    a_r3_pair_only: assert property (@(posedge clk) disable iff (!rst_n)
        awready |-> (awvalid && wvalid));

    a_r3_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    a_r11_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    a_r5_halt_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(dp_stopped || dp_reset_done));

    a_r5_leave_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted) |-> $past(run_req || soft_rst_req));

    a_r7_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ((dp_slv_err || dp_dec_err) && !soft_rst_req) |=> !run_req);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en != 3'b000));

    a_r10_rst_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst_req) |-> $past(dp_reset_done));

endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .wvalid(wvalid),
    .awready(awready), .bvalid(bvalid), .bready(bready),
    .rvalid(rvalid), .rready(rready), .rdata(rdata),
    .halted(chan_halted), .run_req(run_req), .soft_rst_req(soft_rst_req),
    .dp_stopped(dp_stopped), .dp_reset_done(dp_reset_done),
    .dp_slv_err(dp_slv_err), .dp_dec_err(dp_dec_err),
    .irq(irq), .irq_en(irq_en_w)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, arvalid = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        bready = 1'b1, rready = 1'b1;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic        run_req, soft_rst_req, irq;
    logic        dp_stopped = 0, dp_reset_done = 0, dp_xfer_start = 0;
    logic        dp_xfer_done = 0, dp_slv_err = 0, dp_dec_err = 0;
    logic        ev_ioc = 0, ev_dly = 0;

    int applied = 0;
    int bad     = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    dma_chan_regs #(.ADDR_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .run_req(run_req), .soft_rst_req(soft_rst_req),
        .dp_stopped(dp_stopped), .dp_reset_done(dp_reset_done),
        .dp_xfer_start(dp_xfer_start), .dp_xfer_done(dp_xfer_done),
        .dp_slv_err(dp_slv_err), .dp_dec_err(dp_dec_err),
        .ev_ioc(ev_ioc), .ev_dly(ev_dly), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rdata, e);
                check({t, " rresp"}, {30'd0, rresp}, 32'd0);
            end
        end
    end

    task automatic axi_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        do @(posedge clk); while (!awready);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
    endtask

    task automatic axi_read(input logic [5:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        araddr = a; arvalid = 1;
        do @(posedge clk); while (!arready);
        @(negedge clk);
        arvalid = 0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1;
        @(negedge clk); sig = 0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        idle_cycles(4);
        rst_n = 1;
        idle_cycles(2);
        // R1 reset state
        axi_read(6'h00, 32'h0000_0002, "R1 control reset");
        axi_read(6'h04, 32'h0000_0001, "R1 status reset");
        check("R1 run_req", {31'd0, run_req}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 soft_rst_req", {31'd0, soft_rst_req}, 0);

        // R2 R4 all ones except reset bit, zero strobes
        axi_write(6'h00, 32'hFFFF_FFFB, 4'h0);
        axi_read(6'h00, 32'h0000_7003, "R2 R4 control layout");
        check("R2 run_req follows bit 0", {31'd0, run_req}, 1);
        idle_cycles(3);
        axi_read(6'h04, 32'h0000_0000, "R5 R6 running not idle");

        // R6 idle
        pulse(dp_xfer_done);
        axi_read(6'h04, 32'h0000_0002, "R6 idle after done");
        pulse(dp_xfer_start);
        axi_read(6'h04, 32'h0000_0000, "R6 idle cleared by start");

        // R8 R9 interrupt flags
        pulse(ev_ioc);
        idle_cycles(1);
        check("R9 irq with ioc enabled", {31'd0, irq}, 1);
        axi_read(6'h04, 32'h0000_1000, "R8 ioc flag set");
        axi_write(6'h00, 32'h0000_2001, 4'hF);
        idle_cycles(1);
        check("R9 irq masked", {31'd0, irq}, 0);
        axi_read(6'h00, 32'h0000_2003, "R2 control rewrite");
        axi_write(6'h04, 32'h0000_0000, 4'hF);
        axi_read(6'h04, 32'h0000_1000, "R8 write 0 keeps flag");
        axi_write(6'h04, 32'h0000_1000, 4'hF);
        axi_read(6'h04, 32'h0000_0000, "R8 write 1 clears flag");

        // R3 lone write address
        @(negedge clk);
        awaddr = 6'h00; wdata = 32'h0; awvalid = 1;
        repeat (3) begin
            @(negedge clk);
            check("R3 awready without wvalid", {31'd0, awready}, 0);
            check("R3 bvalid without write", {31'd0, bvalid}, 0);
        end
        awvalid = 0;
        axi_read(6'h00, 32'h0000_2003, "R3 lone address no change");

        // R5 halted waits for datapath
        axi_write(6'h00, 32'h0000_2002, 4'hF);
        check("R5 run_req drops", {31'd0, run_req}, 0);
        idle_cycles(5);
        axi_read(6'h04, 32'h0000_0000, "R5 still not halted");
        @(negedge clk); dp_stopped = 1;
        idle_cycles(3);
        dp_stopped = 0;
        axi_read(6'h04, 32'h0000_0001, "R5 halted after stop");

        // R7 errors
        axi_write(6'h00, 32'h0000_4001, 4'hF);
        idle_cycles(3);
        pulse(dp_slv_err);
        idle_cycles(1);
        check("R7 run_req cleared by error", {31'd0, run_req}, 0);
        check("R9 irq on error", {31'd0, irq}, 1);
        axi_read(6'h00, 32'h0000_4002, "R7 run/stop cleared");
        axi_read(6'h04, 32'h0000_4020, "R7 slave error status");
        pulse(dp_stopped);
        axi_read(6'h04, 32'h0000_4021, "R7 halted after error");
        pulse(dp_dec_err);
        axi_read(6'h04, 32'h0000_4061, "R7 decode error status");
        axi_write(6'h04, 32'hFFFF_FFFF, 4'hF);
        axi_read(6'h04, 32'h0000_0061, "R7 R8 sticky errors, flag cleared");
        check("R9 irq after clear", {31'd0, irq}, 0);

        // R11 unmapped offsets
        axi_read(6'h08, 32'h0000_0000, "R11 unmapped read");
        @(negedge clk);
        awaddr = 6'h10; wdata = 32'hFFFF_FFFF; awvalid = 1; wvalid = 1;
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        check("R3 bvalid after write", {31'd0, bvalid}, 1);
        check("R3 bresp okay", {30'd0, bresp}, 0);
        axi_read(6'h00, 32'h0000_4002, "R11 unmapped write no effect");

        // R10 soft reset
        axi_write(6'h00, 32'h0000_0004, 4'hF);
        check("R10 soft_rst_req", {31'd0, soft_rst_req}, 1);
        axi_read(6'h00, 32'h0000_0006, "R10 reset bit reads 1");
        axi_write(6'h00, 32'h0000_1001, 4'hF);
        axi_read(6'h00, 32'h0000_0006, "R10 writes ignored in reset");
        pulse(dp_reset_done);
        check("R10 soft_rst_req released", {31'd0, soft_rst_req}, 0);
        axi_read(6'h00, 32'h0000_0002, "R10 control restored");
        axi_read(6'h04, 32'h0000_0001, "R10 status restored");

        idle_cycles(2);
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule